// File: doc/BRIEF.md
# Masked Mailbox Write Engine

This block carries out 64-bit inter-core messaging commands. Every command delivers a 32-bit payload into one 32-bit register of a target core. A 4-bit keep field can hold on to chosen bytes of the register's present contents. When any keep bit is set, the engine first reads the target word, then writes the merged value. When no keep bit is set, the engine skips the read and writes the whole payload.

There are two command kinds. A slot command addresses one of eight mailbox words above a configurable mailbox base. A direct command carries a full 16-bit register offset. The engine drives a master port towards the target-core register space, which lies outside the block. The port names the core and the offset. Reads use a request/acknowledge handshake and writes use a single-cycle strobe.

The engine takes one command at a time and holds `cmd_ready` low until that command has finished. It reports the outcome with a one-cycle `done` or `err` pulse. A command is rejected when it does not arrive as a full 64-bit write, or when it names a core that does not exist.

Top module: `mbx_wr_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `m_rd_req`, `m_wr`, `done` and `err` are all 0.
- R2: `cmd_ready` is 1 only while the engine is idle. A command is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both 1. A command held on `cmd_valid` while the engine is busy waits, and it is not lost.
- R3: A command taken with `cmd_full` = 0 gives exactly one `err` pulse in the cycle after it is taken. It issues no read and no write.
- R4: The target core is `cmd_data[25:16]` and appears on `m_core`. A value of `NUM_CORES` or more gives the same single `err` pulse as R3, with no read and no write.
- R5: When `cmd_data[30:27]` is 0, no read is issued. `m_wr` rises in the cycle after acceptance with `m_wr_data` = `cmd_data[63:32]`.
- R6: When `cmd_data[30:27]` is nonzero, `m_rd_req` rises in the cycle after acceptance. It stays high until a cycle in which `m_rd_ack` is 1. `m_wr` follows in the next cycle.
- R7: `cmd_data[27+i]` = 1 keeps byte i (bits 8i+7:8i) of the word returned on `m_rd_data`. A 0 takes that byte from the payload `cmd_data[63:32]`.
- R8: With `cmd_any` = 0 (slot command), the offset is `MBOX_BASE` + 0x20 + (`cmd_data` AND 0x1C), taken modulo 2^16.
- R9: With `cmd_any` = 1 (direct command), the offset is `cmd_data[15:0]`.
- R10: `done` pulses for one cycle in the cycle after the `m_wr` cycle. `cmd_ready` returns in the cycle after `done` or `err`. At most one of `m_rd_req`, `m_wr`, `done` and `err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command may be taken |
| cmd_any | input | 1 | 0 = slot command, 1 = direct-offset command |
| cmd_full | input | 1 | 1 when the command arrived as a full 64-bit write |
| cmd_data | input | 64 | Command word (payload, keep field, core, offset) |
| m_core | output | 10 | Target core identifier |
| m_addr | output | 16 | Target register offset |
| m_rd_req | output | 1 | Read request, held until acknowledged |
| m_rd_ack | input | 1 | Read data valid |
| m_rd_data | input | 32 | Word read from target |
| m_wr | output | 1 | Single-cycle write strobe |
| m_wr_data | output | 32 | Word to write |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
Acceptance happens on an edge. The result then follows a fixed schedule. For a rejected command, `err` is due one cycle later. For a command with no keep bits, `m_wr` is due one cycle later and `done` one cycle after that. For a command with keep bits, the read request stays up through the acknowledge edge, and `m_wr` and `done` then follow in the next two cycles. The bench runs a phase model that advances on the same edges as the design. Every output is compared against that model at each falling edge, half a cycle after the edge that produced it. Read latency is varied so that the hold of the request is exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int CMD_W  = 64;
  localparam int WORD_W = 32;
  localparam int CORE_W = 10;
  localparam int OFFS_W = 16;
  localparam int LANES  = WORD_W / 8;

  // Command field positions
  localparam int PAY_LSB  = 32;
  localparam int KEEP_LSB = 27;
  localparam int CORE_LSB = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_DONE,
    ST_FAIL
  } mbx_state_e;

  // Mailbox slot offset: base + 0x20 + 4*slot
  function automatic logic [OFFS_W-1:0] slot_offset(input logic [OFFS_W-1:0] base,
                                                     input logic [2:0] slot);
    return base + 16'h0020 + {11'b0, slot, 2'b00};
  endfunction

  // Core identifier beyond populated range
  function automatic logic core_absent(input logic [CORE_W-1:0] core,
                                       input logic [CORE_W:0] limit);
    return ({1'b0, core} >= limit);
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter logic [15:0] MBOX_BASE = 16'h0800
) (
  input  logic [CMD_W-1:0]  cmd,
  input  logic              is_any,
  input  logic              is_full,
  output logic [CORE_W-1:0] core,
  output logic [OFFS_W-1:0] offs,
  output logic [LANES-1:0]  keep,
  output logic [WORD_W-1:0] payload,
  output logic              reject
);
  localparam logic [CORE_W:0] CORE_LIM = NUM_CORES[CORE_W:0];

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd[31], cmd[26]};

  assign core    = cmd[CORE_LSB +: CORE_W];
  assign keep    = cmd[KEEP_LSB +: LANES];
  assign payload = cmd[PAY_LSB +: WORD_W];
  assign offs    = is_any ? cmd[OFFS_W-1:0] : slot_offset(MBOX_BASE, cmd[4:2]);
  assign reject  = !is_full || core_absent(core, CORE_LIM);
endmodule

// File: rtl/mbx_merge.sv
module mbx_merge
  import mbx_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [LANES-1:0]  keep,
  output logic [WORD_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = keep[g] ? old_word[g*8 +: 8] : new_word[g*8 +: 8];
  end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              reject,
  input  logic [CORE_W-1:0] in_core,
  input  logic [OFFS_W-1:0] in_offs,
  input  logic [LANES-1:0]  in_keep,
  input  logic [WORD_W-1:0] in_payload,
  input  logic              rd_ack,
  input  logic [WORD_W-1:0] merged,
  output logic              idle,
  output logic              rd_req,
  output logic              wr,
  output logic              fin_ok,
  output logic              fin_bad,
  output logic [CORE_W-1:0] core_q,
  output logic [OFFS_W-1:0] offs_q,
  output logic [LANES-1:0]  keep_q,
  output logic [WORD_W-1:0] pay_q,
  output logic [WORD_W-1:0] wdata_q
);
  mbx_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      core_q  <= '0;
      offs_q  <= '0;
      keep_q  <= '0;
      pay_q   <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (take) begin
          core_q  <= in_core;
          offs_q  <= in_offs;
          keep_q  <= in_keep;
          pay_q   <= in_payload;
          wdata_q <= in_payload;
          if (reject)              state <= ST_FAIL;
          else if (in_keep == '0)  state <= ST_WRITE;
          else                     state <= ST_READ;
        end
        ST_READ: if (rd_ack) begin
          wdata_q <= merged;
          state   <= ST_WRITE;
        end
        ST_WRITE: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        ST_FAIL:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (state == ST_IDLE);
  assign rd_req  = (state == ST_READ);
  assign wr      = (state == ST_WRITE);
  assign fin_ok  = (state == ST_DONE);
  assign fin_bad = (state == ST_FAIL);
endmodule

// File: rtl/mbx_wr_engine.sv
module mbx_wr_engine
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter logic [15:0] MBOX_BASE = 16'h0800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_any,
  input  logic        cmd_full,
  input  logic [63:0] cmd_data,
  output logic [9:0]  m_core,
  output logic [15:0] m_addr,
  output logic        m_rd_req,
  input  logic        m_rd_ack,
  input  logic [31:0] m_rd_data,
  output logic        m_wr,
  output logic [31:0] m_wr_data,
  output logic        done,
  output logic        err
);
  logic [CORE_W-1:0] dec_core;
  logic [OFFS_W-1:0] dec_offs;
  logic [LANES-1:0]  dec_keep;
  logic [WORD_W-1:0] dec_payload;
  logic              dec_reject;
  logic [LANES-1:0]  keep_q;
  logic [WORD_W-1:0] pay_q;
  logic [WORD_W-1:0] merged;

  // Named events for the checker
  logic acc, acc_bad, acc_nokeep;

  mbx_decode #(.NUM_CORES(NUM_CORES), .MBOX_BASE(MBOX_BASE)) u_dec (
    .cmd(cmd_data), .is_any(cmd_any), .is_full(cmd_full),
    .core(dec_core), .offs(dec_offs), .keep(dec_keep),
    .payload(dec_payload), .reject(dec_reject)
  );

  assign acc        = cmd_valid && cmd_ready;
  assign acc_bad    = acc && dec_reject;
  assign acc_nokeep = acc && (dec_keep == '0);

  mbx_merge u_mrg (
    .old_word(m_rd_data), .new_word(pay_q), .keep(keep_q), .merged(merged)
  );

  mbx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .take(acc), .reject(dec_reject),
    .in_core(dec_core), .in_offs(dec_offs), .in_keep(dec_keep),
    .in_payload(dec_payload), .rd_ack(m_rd_ack), .merged(merged),
    .idle(cmd_ready), .rd_req(m_rd_req), .wr(m_wr),
    .fin_ok(done), .fin_bad(err),
    .core_q(m_core), .offs_q(m_addr), .keep_q(keep_q), .pay_q(pay_q),
    .wdata_q(m_wr_data)
  );
endmodule

// File: rtl/mbx_wr_engine_chk.sv
module mbx_wr_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        m_rd_req,
  input logic        m_rd_ack,
  input logic        m_wr,
  input logic        done,
  input logic        err,
  input logic [9:0]  m_core,
  input logic [15:0] m_addr,
  input logic        acc,
  input logic        acc_bad,
  input logic        acc_nokeep
);
  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd_req || m_wr || done || err) |-> !cmd_ready);

  p_reject_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> (err && !m_rd_req && !m_wr));

  p_err_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!err && cmd_ready));

  p_skip_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_bad && acc_nokeep) |=> (m_wr && !m_rd_req));

  p_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_bad && !acc_nokeep) |=> m_rd_req);

  p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd_req && !m_rd_ack) |=> m_rd_req);

  p_target_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd_req && m_rd_ack) |=> (m_wr && $stable(m_addr) && $stable(m_core)));

  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr |=> (done && !m_wr));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_rd_req, m_wr, done, err}));
endmodule

bind mbx_wr_engine mbx_wr_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .m_rd_req(m_rd_req), .m_rd_ack(m_rd_ack), .m_wr(m_wr),
  .done(done), .err(err), .m_core(m_core), .m_addr(m_addr),
  .acc(acc), .acc_bad(acc_bad), .acc_nokeep(acc_nokeep)
);

// File: tb/sim_mbx_wr_engine.sv
`timescale 1ns/1ps
module sim_mbx_wr_engine;
  localparam int NCORES = 4;
  localparam int BASE   = 'h0800;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0, cmd_any = 0, cmd_full = 1;
  logic [63:0] cmd_data = '0;
  logic        cmd_ready;
  logic [9:0]  m_core;
  logic [15:0] m_addr;
  logic        m_rd_req, m_wr, done, err;
  logic        m_rd_ack = 0;
  logic [31:0] m_rd_data = '0;
  logic [31:0] m_wr_data;

  always #5 clk = ~clk;

  mbx_wr_engine #(.NUM_CORES(NCORES), .MBOX_BASE(16'(BASE))) u0 (.*);

  int checks = 0, failures = 0;
  int wr_count = 0;
  int rd_lat = 0;
  logic [31:0] mem [int];

  function automatic logic [31:0] peek(int key);
    if (mem.exists(key)) return mem[key];
    return 32'(key * 32'h9E3779B1 + 32'h1234);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Target register space
  always @(posedge clk) if (rst_n && m_wr) begin
    mem[int'(m_core) * 65536 + int'(m_addr)] = m_wr_data;
    wr_count++;
  end

  int lat_cnt = 0;
  always @(negedge clk) begin
    if (m_rd_req && !m_rd_ack) begin
      if (lat_cnt >= rd_lat) begin
        m_rd_ack  <= 1;
        m_rd_data <= peek(int'(m_core) * 65536 + int'(m_addr));
      end else lat_cnt++;
    end else begin
      m_rd_ack <= 0;
      lat_cnt  = 0;
    end
  end

  // Behavioural reference: phase 0 idle,1 reading,2 writing,3 done,4 error
  int ph = 0;
  int e_core = 0, e_addr = 0, e_any = 0;
  longint e_pay = 0, e_wv = 0;
  int e_keep = 0;

  function automatic longint byte_mask(int k);
    longint m = 0;
    for (int i = 0; i < 4; i++) if ((k >> i) & 1) m += longint'(255) << (8 * i);
    return m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ph <= 0;
    else case (ph)
      0: if (cmd_valid) begin
        e_core <= int'(cmd_data[25:16]);
        e_any  <= int'(cmd_any);
        e_keep <= int'(cmd_data[30:27]);
        e_pay  <= longint'(cmd_data[63:32]);
        e_wv   <= longint'(cmd_data[63:32]);
        e_addr <= cmd_any ? int'(cmd_data[15:0])
                          : (BASE + 32 + int'(cmd_data[31:0] & 32'h1C)) % 65536;
        if (!cmd_full || int'(cmd_data[25:16]) >= NCORES) ph <= 4;
        else if (cmd_data[30:27] == 0) ph <= 2;
        else ph <= 1;
      end
      1: if (m_rd_ack) begin
        e_wv <= (longint'(m_rd_data) & byte_mask(e_keep)) |
                (e_pay & (longint'(32'hFFFFFFFF) - byte_mask(e_keep)));
        ph <= 2;
      end
      2: ph <= 3;
      default: ph <= 0;
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    chk(cmd_ready == (ph == 0), "R2 ready", cmd_ready, ph == 0);
    chk(m_rd_req == (ph == 1), "R6 read request", m_rd_req, ph == 1);
    chk(m_wr == (ph == 2), "R5 write strobe", m_wr, ph == 2);
    chk(done == (ph == 3), "R10 done pulse", done, ph == 3);
    chk(err == (ph == 4), "R4 error pulse", err, ph == 4);
    if (ph == 1 || ph == 2) begin
      chk(int'(m_core) == e_core, "R4 core", m_core, e_core);
      chk(int'(m_addr) == e_addr, e_any ? "R9 direct offset" : "R8 slot offset", m_addr, e_addr);
    end
    if (ph == 2) chk(longint'(m_wr_data) == e_wv, "R7 write data", m_wr_data, e_wv);
  end

  task automatic send(input bit any, input bit full, input logic [63:0] d);
    bit r;
    cmd_valid = 1; cmd_any = any; cmd_full = full; cmd_data = d;
    do begin r = cmd_ready; @(negedge clk); end while (!r);
    cmd_valid = 0;
  endtask

  task automatic settle();
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] mk(logic [31:0] pay, logic [3:0] keep, logic [9:0] core, logic [15:0] off);
    return {pay, 1'b0, keep, 1'b0, core, off};
  endfunction

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready === 1'b1, "R1 ready", cmd_ready, 1);
    chk({m_rd_req, m_wr, done, err} === 4'b0, "R1 strobes", {m_rd_req, m_wr, done, err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 R8 slot, no keep, slot 3 -> 0x0800+0x20+0xC
    send(0, 1, mk(32'hCAFEF00D, 4'h0, 10'd1, 16'h000C)); settle();
    chk(peek(1 * 65536 + 'h082C) == 32'hCAFEF00D, "R8 slot word", peek(1 * 65536 + 'h082C), 32'hCAFEF00D);

    // R7 partial keep with known old value
    mem[2 * 65536 + 'h0100] = 32'hAABBCCDD;
    rd_lat = 2;
    send(1, 1, mk(32'h11223344, 4'b0101, 10'd2, 16'h0100)); settle();
    chk(peek(2 * 65536 + 'h0100) == 32'h11BB33DD, "R7 merge", peek(2 * 65536 + 'h0100), 32'h11BB33DD);

    // R7 full keep rewrites old word
    mem[3 * 65536 + 'h0040] = 32'h0F1E2D3C;
    rd_lat = 0;
    send(1, 1, mk(32'hFFFFFFFF, 4'hF, 10'd3, 16'h0040)); settle();
    chk(peek(3 * 65536 + 'h0040) == 32'h0F1E2D3C, "R7 keep all", peek(3 * 65536 + 'h0040), 32'h0F1E2D3C);

    // R6 long read latency, top byte kept
    rd_lat = 5;
    send(0, 1, mk(32'h01020304, 4'b1000, 10'd0, 16'h001C)); settle();

    // R3 and R4 rejects leave target untouched
    w0 = wr_count;
    send(1, 0, mk(32'h5, 4'h0, 10'd0, 16'h0010)); settle();
    chk(wr_count == w0, "R3 no write", wr_count, w0);
    send(1, 1, mk(32'h6, 4'h3, 10'd4, 16'h0010)); settle();
    send(1, 1, mk(32'h7, 4'h0, 10'h3FF, 16'h0010)); settle();
    chk(wr_count == w0, "R4 no write", wr_count, w0);

    // R2 back-to-back: second command held during first
    rd_lat = 1;
    send(0, 1, mk(32'hA1A2A3A4, 4'b0010, 10'd1, 16'h0000));
    send(1, 1, mk(32'hB1B2B3B4, 4'h0, 10'd2, 16'hFFFC));
    settle();
    chk(peek(2 * 65536 + 'hFFFC) == 32'hB1B2B3B4, "R2 held command", peek(2 * 65536 + 'hFFFC), 32'hB1B2B3B4);

    // Mixed stream
    for (int n = 0; n < 60; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      d[25:16] = 10'($urandom % 6);
      rd_lat = $urandom % 4;
      send(1'($urandom), ($urandom % 8) != 0, d);
    end
    settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule